// File: doc/BRIEF.md
# ASID-Ring Translation Buffer with Rotating Refill

This block translates 32-bit virtual addresses into physical addresses for one processor. It holds four software-refilled ways of 4 KiB pages, organised as small sets selected by low page-number bits. It also holds two read-only ways of large pages that are present from reset. Each entry carries a page number, a physical frame, an 8-bit address-space identifier and a 4-bit attribute code.

A lookup compares every way in parallel. The identifier of a matching entry is turned into a privilege ring by a 32-bit ring register, which stores one identifier per ring. Privilege and access type are then checked. One cycle later the block returns one of two things: the physical address with its rights and cache class, or a fault code. Each lookup also returns the address of the page-table entry that a walker would fetch on a miss.

The walker itself sits outside the block. It hands a fetched page-table entry back through the refill port. A rotating counter picks the way that the refill writes.

Top module: `tlb_asid_ring`

## Requirements
- R1: After reset the ring register holds 0x04030201 and every refill entry has identifier 0, so every lookup outside the read-only regions misses. The refill counter is 0.
- R2: An identifier belongs to ring k when byte k (bits 8k+7:8k) of the ring register is the lowest byte equal to it. An identifier that equals no byte has no ring, and its entry never hits. A write on rasid_we replaces the ring register.
- R3: An entry hits when three things hold: its page number matches, its identifier is non-zero, and the identifier has a ring. No hit gives fault 16 for fetches and fault 24 for data accesses.
- R4: Two or more hitting ways give fault 17 for fetches and fault 25 for data accesses. This check comes before any privilege check.
- R5: When exactly one way hits and its ring is numerically lower than lk_priv, the fault is 18 for fetches and 26 for data accesses.
- R6: Attribute decode. Codes 0 to 11 grant read; bit 0 adds execute and bit 1 adds write. Bits 3:2 of those codes select the cache class: 0 is bypass (class 1), 1 is write-back (class 2) and 2 is write-through (class 3). Code 13 grants read and write with cache class isolate (4). Every other code grants nothing and has class 0. res_rights is {execute, write, read}.
- R7: lk_kind is 0 for load, 1 for store, 2 for fetch and 3 for a reserved kind that is never granted. Fetches drop read and write rights; data accesses drop execute. A missing right gives fault 20 for a fetch, 28 for a load and 29 for a store or reserved kind.
- R8: On success the fault code is 0, and the physical address is the frame ORed with the page offset. The offset is 12 bits for refill ways, 27 bits for the 0xD region and 28 bits for the 0xE/0xF region. On any fault, res_paddr, res_rights, res_cache and res_ring are 0.
- R9: res_pte_addr equals (pte_base OR (lk_vaddr >> 10)) with its two low bits cleared.
- R10: A refill writes the page number rf_vpn, the frame rf_pte[31:12] and the attribute rf_pte[3:0]. Its identifier is the ring-register byte selected by rf_pte[5:4]. The set is given by rf_vpn[1:0]. The way is the counter plus one modulo 4, and that value becomes the new counter, so the ways run 1, 2, 3, 0 after reset. Without a refill, the stored entries stay unchanged.
- R11: The read-only ways use identifier 1. The first maps 0xD0000000 to physical 0 with attribute 7 and 0xD8000000 to physical 0 with attribute 3, on 128 MiB pages. The second maps 0xE0000000 to 0xF0000000 with attribute 7 and 0xF0000000 to 0xF0000000 with attribute 3, on 256 MiB pages.
- R12: res_valid follows lk_valid one cycle later. A lookup sees the entries and ring register as they were before any refill or ring write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rasid_we | input | 1 | Write enable for the ring register |
| rasid_wdata | input | 32 | New ring register value |
| pte_base | input | 32 | Page-table base for the entry address |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| lk_priv | input | 2 | Requested privilege index |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | 20 | Virtual page number of the refilled page |
| rf_pte | input | 32 | Page-table entry being installed |
| res_valid | output | 1 | Result valid, one cycle after lk_valid |
| res_cause | output | 6 | Fault code, 0 on success |
| res_paddr | output | 32 | Physical address |
| res_rights | output | 3 | Granted rights {execute, write, read} after side masking |
| res_cache | output | 3 | Cache class |
| res_ring | output | 2 | Ring of the hitting entry |
| res_pte_addr | output | 32 | Page-table entry address for the looked-up address |

## Verification
The state inside the block is the ring register, the stored entries and the refill counter. A corrupted entry or ring byte shows up on the next lookup of that page, one cycle after the request, as a wrong fault code, frame or ring. A counter that advances wrongly is exposed later: a refill replaces the wrong way, and the error appears either as a stale page that should have been evicted but still hits, or as a false multi-hit fault on a page refilled twice. The bench therefore refills a small pool of pages repeatedly and rewrites the ring register at random, so that these errors are seen within a few refills.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W  = 32;
    localparam int PG_W  = 12;
    localparam int VPN_W = VA_W - PG_W;

    localparam logic [1:0] KIND_LOAD  = 2'd0;
    localparam logic [1:0] KIND_STORE = 2'd1;
    localparam logic [1:0] KIND_FETCH = 2'd2;

    localparam logic [5:0] CA_OK       = 6'd0;
    localparam logic [5:0] CA_I_MISS   = 6'd16;
    localparam logic [5:0] CA_I_MULTI  = 6'd17;
    localparam logic [5:0] CA_I_PRIV   = 6'd18;
    localparam logic [5:0] CA_I_DENY   = 6'd20;
    localparam logic [5:0] CA_D_MISS   = 6'd24;
    localparam logic [5:0] CA_D_MULTI  = 6'd25;
    localparam logic [5:0] CA_D_PRIV   = 6'd26;
    localparam logic [5:0] CA_LD_DENY  = 6'd28;
    localparam logic [5:0] CA_ST_DENY  = 6'd29;

    localparam logic [2:0] CH_NONE = 3'd0;
    localparam logic [2:0] CH_BYP  = 3'd1;
    localparam logic [2:0] CH_WB   = 3'd2;
    localparam logic [2:0] CH_WT   = 3'd3;
    localparam logic [2:0] CH_ISO  = 3'd4;

    localparam logic [31:0] RASID_RST  = 32'h0403_0201;
    localparam logic [7:0]  FIXED_ASID = 8'd1;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [VPN_W-1:0] ppn;
        logic [7:0]       asid;
        logic [3:0]       attr;
    } tlb_ent_t;

    typedef struct packed {
        logic            valid;
        logic [5:0]      cause;
        logic [VA_W-1:0] pa;
        logic [2:0]      rights;
        logic [2:0]      cache;
        logic [1:0]      ring;
        logic [VA_W-1:0] pte_addr;
    } tlb_res_t;

    // rights {x,w,r} and cache class for an attribute code
    function automatic logic [5:0] attr_decode(input logic [3:0] a);
        logic [2:0] rt;
        logic [2:0] ch;
        rt = 3'b000;
        ch = CH_NONE;
        if (a < 4'd12) begin
            rt = {a[0], a[1], 1'b1};
            case (a[3:2])
                2'd0:    ch = CH_BYP;
                2'd1:    ch = CH_WB;
                default: ch = CH_WT;
            endcase
        end else if (a == 4'd13) begin
            rt = 3'b011;
            ch = CH_ISO;
        end
        return {rt, ch};
    endfunction

endpackage

// File: rtl/tlb_ring_map.sv
module tlb_ring_map (
    input  logic [31:0] rasid_i,
    input  logic [7:0]  asid_i,
    output logic        found_o,
    output logic [1:0]  ring_o
);
    // lowest matching byte wins: scan downward so the last write is the lowest
    always_comb begin
        found_o = 1'b0;
        ring_o  = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (rasid_i[8*i +: 8] == asid_i) begin
                found_o = 1'b1;
                ring_o  = 2'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_fixed_ways.sv
module tlb_fixed_ways
    import tlb_pkg::*;
(
    input  logic [VA_W-1:0]       va_i,
    output logic [1:0]            hit_o,
    output logic [1:0][3:0]       attr_o,
    output logic [1:0][VA_W-1:0]  pa_o
);
    // way A: 128 MiB pages in the 0xD region, entry picked by bit 27
    localparam logic [1:0][31:0] FXA_V    = {32'hD800_0000, 32'hD000_0000};
    localparam logic [1:0][31:0] FXA_P    = {32'h0000_0000, 32'h0000_0000};
    localparam logic [1:0][3:0]  FXA_ATTR = {4'd3, 4'd7};
    // way B: 256 MiB pages covering 0xE/0xF, entry picked by bit 28
    localparam logic [1:0][31:0] FXB_V    = {32'hF000_0000, 32'hE000_0000};
    localparam logic [1:0][31:0] FXB_P    = {32'hF000_0000, 32'hF000_0000};
    localparam logic [1:0][3:0]  FXB_ATTR = {4'd3, 4'd7};

    logic ia, ib;

    always_comb begin
        ia        = va_i[27];
        ib        = va_i[28];
        hit_o[0]  = (va_i[31:27] == FXA_V[ia][31:27]);
        attr_o[0] = FXA_ATTR[ia];
        pa_o[0]   = FXA_P[ia] | {5'b0, va_i[26:0]};
        hit_o[1]  = (va_i[31:28] == FXB_V[ib][31:28]);
        attr_o[1] = FXB_ATTR[ib];
        pa_o[1]   = FXB_P[ib] | {4'b0, va_i[27:0]};
    end
endmodule

// File: rtl/tlb_refill_array.sv
module tlb_refill_array
    import tlb_pkg::*;
#(
    parameter int NW   = 4,
    parameter int SETS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rf_valid,
    input  logic [VPN_W-1:0]           rf_vpn,
    input  logic [VPN_W-1:0]           rf_ppn,
    input  logic [7:0]                 rf_asid,
    input  logic [3:0]                 rf_attr,
    input  logic [VPN_W-1:0]           lk_vpn,
    output tlb_ent_t [NW-1:0]          ent_o,
    output logic [NW-1:0]              vhit_o
);
    localparam int RRW  = $clog2(NW);
    localparam int IDXW = $clog2(SETS);

    typedef struct packed {
        tlb_ent_t [NW-1:0][SETS-1:0] ent;
        logic [RRW-1:0]              rr;
    } arr_st_t;

    arr_st_t        st_d, st_q;
    logic [RRW-1:0] wsel;
    logic [IDXW-1:0] wset, lset;

    always_comb begin
        st_d = st_q;
        wsel = st_q.rr + 1'b1;
        wset = rf_vpn[IDXW-1:0];
        if (rf_valid) begin
            st_d.rr              = wsel;
            st_d.ent[wsel][wset] = '{vpn: rf_vpn, ppn: rf_ppn, asid: rf_asid, attr: rf_attr};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lset = lk_vpn[IDXW-1:0];

    for (genvar w = 0; w < NW; w++) begin : g_cmp
        assign ent_o[w]  = st_q.ent[w][lset];
        assign vhit_o[w] = (st_q.ent[w][lset].vpn == lk_vpn) && (st_q.ent[w][lset].asid != 8'd0);
    end

    // R10
    array_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_valid |=> $stable(st_q));
endmodule

// File: rtl/tlb_asid_ring.sv
module tlb_asid_ring
    import tlb_pkg::*;
#(
    parameter int NW_REFILL = 4,
    parameter int SETS      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rasid_we,
    input  logic [31:0]       rasid_wdata,
    input  logic [31:0]       pte_base,
    input  logic              lk_valid,
    input  logic [31:0]       lk_vaddr,
    input  logic [1:0]        lk_kind,
    input  logic [1:0]        lk_priv,
    input  logic              rf_valid,
    input  logic [19:0]       rf_vpn,
    input  logic [31:0]       rf_pte,
    output logic              res_valid,
    output logic [5:0]        res_cause,
    output logic [31:0]       res_paddr,
    output logic [2:0]        res_rights,
    output logic [2:0]        res_cache,
    output logic [1:0]        res_ring,
    output logic [31:0]       res_pte_addr
);
    localparam int NT  = NW_REFILL + 2;
    localparam int NHW = $clog2(NT + 1);

    typedef struct packed {
        logic [31:0] rasid;
        tlb_res_t    res;
    } top_st_t;

    top_st_t st_d, st_q;

    tlb_ent_t [NW_REFILL-1:0] rf_ent;
    logic [NW_REFILL-1:0]     rf_vhit;
    logic [1:0]               fx_hit;
    logic [1:0][3:0]          fx_attr;
    logic [1:0][31:0]         fx_pa;
    logic [7:0]               rf_asid;
    logic                     unused_pte_bits;

    logic [NT-1:0] vhit, rfound, hits;
    logic [7:0]    asid_v [NT];
    logic [3:0]    attr_v [NT];
    logic [31:0]   pa_v   [NT];
    logic [1:0]    rring  [NT];

    logic [NHW-1:0] nh;
    logic [3:0]     sel_attr;
    logic [31:0]    sel_pa;
    logic [1:0]     sel_ring;
    logic [2:0]     dec_rt, dec_ch, rt_m;
    logic           fetch, grant;

    assign rf_asid         = st_q.rasid[{rf_pte[5:4], 3'b000} +: 8];
    assign unused_pte_bits = ^rf_pte[11:6];

    tlb_refill_array #(.NW(NW_REFILL), .SETS(SETS)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_pte[31:12]),
        .rf_asid(rf_asid), .rf_attr(rf_pte[3:0]),
        .lk_vpn(lk_vaddr[31:12]),
        .ent_o(rf_ent), .vhit_o(rf_vhit)
    );

    tlb_fixed_ways u_fix (
        .va_i(lk_vaddr), .hit_o(fx_hit), .attr_o(fx_attr), .pa_o(fx_pa)
    );

    for (genvar w = 0; w < NT; w++) begin : g_way
        if (w < NW_REFILL) begin : g_rf
            assign asid_v[w] = rf_ent[w].asid;
            assign attr_v[w] = rf_ent[w].attr;
            assign pa_v[w]   = {rf_ent[w].ppn, lk_vaddr[PG_W-1:0]};
            assign vhit[w]   = rf_vhit[w];
        end else begin : g_fx
            assign asid_v[w] = FIXED_ASID;
            assign attr_v[w] = fx_attr[w-NW_REFILL];
            assign pa_v[w]   = fx_pa[w-NW_REFILL];
            assign vhit[w]   = fx_hit[w-NW_REFILL];
        end
        tlb_ring_map u_rmap (
            .rasid_i(st_q.rasid), .asid_i(asid_v[w]),
            .found_o(rfound[w]), .ring_o(rring[w])
        );
    end

    assign hits = vhit & rfound;

    always_comb begin
        st_d     = st_q;
        nh       = NHW'($countones(hits));
        sel_attr = 4'd0;
        sel_pa   = 32'd0;
        sel_ring = 2'd0;
        for (int w = 0; w < NT; w++) begin
            if (hits[w]) begin
                sel_attr = attr_v[w];
                sel_pa   = pa_v[w];
                sel_ring = rring[w];
            end
        end
        {dec_rt, dec_ch} = attr_decode(sel_attr);
        fetch = (lk_kind == KIND_FETCH);
        rt_m  = fetch ? (dec_rt & 3'b100) : (dec_rt & 3'b011);
        case (lk_kind)
            KIND_LOAD:  grant = rt_m[0];
            KIND_STORE: grant = rt_m[1];
            KIND_FETCH: grant = rt_m[2];
            default:    grant = 1'b0;
        endcase

        if (rasid_we) st_d.rasid = rasid_wdata;

        st_d.res.valid = lk_valid;
        if (lk_valid) begin
            st_d.res          = '0;
            st_d.res.valid    = 1'b1;
            st_d.res.pte_addr = (pte_base | (lk_vaddr >> 10)) & ~32'd3;
            if (nh == '0)
                st_d.res.cause = fetch ? CA_I_MISS : CA_D_MISS;
            else if (nh > NHW'(1))
                st_d.res.cause = fetch ? CA_I_MULTI : CA_D_MULTI;
            else if (sel_ring < lk_priv)
                st_d.res.cause = fetch ? CA_I_PRIV : CA_D_PRIV;
            else if (!grant)
                st_d.res.cause = fetch ? CA_I_DENY :
                                 ((lk_kind == KIND_LOAD) ? CA_LD_DENY : CA_ST_DENY);
            else begin
                st_d.res.cause  = CA_OK;
                st_d.res.pa     = sel_pa;
                st_d.res.rights = rt_m;
                st_d.res.cache  = dec_ch;
                st_d.res.ring   = sel_ring;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.rasid <= RASID_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid    = st_q.res.valid;
    assign res_cause    = st_q.res.cause;
    assign res_paddr    = st_q.res.pa;
    assign res_rights   = st_q.res.rights;
    assign res_cache    = st_q.res.cache;
    assign res_ring     = st_q.res.ring;
    assign res_pte_addr = st_q.res.pte_addr;

    // R12
    lookup_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    // R4
    multi_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && nh > NHW'(1)) |=> (res_cause == CA_I_MULTI || res_cause == CA_D_MULTI));
    // R5
    priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && nh == NHW'(1) && sel_ring < lk_priv) |=>
        (res_cause == CA_I_PRIV || res_cause == CA_D_PRIV));
    // R7
    grant_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_cause == CA_OK) |-> (res_rights != 3'b000));
    // R7
    fetch_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_kind == KIND_FETCH) |=> (res_rights[1:0] == 2'b00));
endmodule

// File: tb/tb_tlb_asid_ring.sv
`timescale 1ns/1ps
module tb_tlb_asid_ring;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rasid_we = 1'b0;
    logic [31:0] rasid_wdata = '0;
    logic [31:0] pte_base = 32'hC000_0000;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_kind = '0;
    logic [1:0]  lk_priv = '0;
    logic        rf_valid = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [31:0] rf_pte = '0;
    logic        res_valid;
    logic [5:0]  res_cause;
    logic [31:0] res_paddr;
    logic [2:0]  res_rights;
    logic [2:0]  res_cache;
    logic [1:0]  res_ring;
    logic [31:0] res_pte_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tlb_asid_ring dut (
        .clk(clk), .rst_n(rst_n), .rasid_we(rasid_we), .rasid_wdata(rasid_wdata),
        .pte_base(pte_base), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_kind(lk_kind), .lk_priv(lk_priv), .rf_valid(rf_valid), .rf_vpn(rf_vpn),
        .rf_pte(rf_pte), .res_valid(res_valid), .res_cause(res_cause),
        .res_paddr(res_paddr), .res_rights(res_rights), .res_cache(res_cache),
        .res_ring(res_ring), .res_pte_addr(res_pte_addr)
    );

    // reference state
    logic [19:0] m_vpn  [4][4];
    logic [19:0] m_ppn  [4][4];
    logic [7:0]  m_asid [4][4];
    logic [3:0]  m_attr [4][4];
    logic [31:0] m_rasid;
    int          m_rr;

    function automatic int ring_of(input logic [7:0] a);
        for (int i = 0; i < 4; i++) if (m_rasid[8*i +: 8] == a) return i;
        return 4;
    endfunction

    function automatic logic [77:0] expect_vec(input logic [31:0] va, input logic [1:0] kind,
                                               input logic [1:0] priv);
        int nh, s, hring;
        logic [3:0] hattr;
        logic [31:0] hpa, pa, pta;
        logic [5:0] c;
        logic [2:0] rt, ch;
        logic [1:0] rg;
        logic r, w, x, g, fe;
        nh = 0; hattr = 0; hpa = 0; hring = 0;
        fe = (kind == 2'd2);
        s = int'(va[13:12]);
        for (int k = 0; k < 4; k++) begin
            if (m_vpn[k][s] == va[31:12] && m_asid[k][s] != 8'd0 && ring_of(m_asid[k][s]) < 4) begin
                nh++; hattr = m_attr[k][s]; hpa = {m_ppn[k][s], va[11:0]}; hring = ring_of(m_asid[k][s]);
            end
        end
        if (va[31:28] == 4'hD && ring_of(8'd1) < 4) begin
            nh++; hattr = va[27] ? 4'd3 : 4'd7; hpa = {5'd0, va[26:0]}; hring = ring_of(8'd1);
        end
        if (va[31:29] == 3'b111 && ring_of(8'd1) < 4) begin
            nh++; hattr = va[28] ? 4'd3 : 4'd7; hpa = {4'hF, va[27:0]}; hring = ring_of(8'd1);
        end
        c = 0; pa = 0; rt = 0; ch = 0; rg = 0;
        if (nh == 0) c = fe ? 6'd16 : 6'd24;
        else if (nh > 1) c = fe ? 6'd17 : 6'd25;
        else if (hring < int'(priv)) c = fe ? 6'd18 : 6'd26;
        else begin
            r = 0; w = 0; x = 0; ch = 0;
            if (hattr < 12) begin
                r = 1; x = hattr[0]; w = hattr[1];
                ch = (hattr[3:2] == 0) ? 3'd1 : (hattr[3:2] == 1) ? 3'd2 : 3'd3;
            end else if (hattr == 13) begin
                r = 1; w = 1; ch = 3'd4;
            end
            if (fe) begin r = 0; w = 0; end else x = 0;
            g = (kind == 0) ? r : (kind == 1) ? w : (kind == 2) ? x : 1'b0;
            if (!g) begin
                c = fe ? 6'd20 : ((kind == 0) ? 6'd28 : 6'd29);
                ch = 0;
            end else begin
                pa = hpa; rt = {x, w, r}; rg = 2'(hring);
            end
        end
        pta = (pte_base | (va >> 10)) & 32'hFFFF_FFFC;
        return {c, pa, rt, ch, rg, pta};
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_refill(input logic [19:0] vpn, input logic [31:0] pte);
        int s;
        s = int'(vpn[1:0]);
        m_rr = (m_rr + 1) % 4;
        m_vpn[m_rr][s]  = vpn;
        m_ppn[m_rr][s]  = pte[31:12];
        m_asid[m_rr][s] = m_rasid[8*pte[5:4] +: 8];
        m_attr[m_rr][s] = pte[3:0];
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [31:0] pte);
        @(negedge clk);
        rf_valid = 1; rf_vpn = vpn; rf_pte = pte;
        model_refill(vpn, pte);
        @(negedge clk);
        rf_valid = 0;
    endtask

    task automatic set_rasid(input logic [31:0] v);
        @(negedge clk);
        rasid_we = 1; rasid_wdata = v;
        @(negedge clk);
        rasid_we = 0;
        m_rasid = v;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] priv,
                          input string tag);
        logic [77:0] e;
        @(negedge clk);
        lk_valid = 1; lk_vaddr = va; lk_kind = kind; lk_priv = priv;
        e = expect_vec(va, kind, priv);
        @(negedge clk);
        lk_valid = 0;
        check(tag, 128'({res_valid, res_cause, res_paddr, res_rights, res_cache, res_ring, res_pte_addr}),
              128'({1'b1, e}));
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [19:0] pool [8];
        logic [77:0] e;
        void'($urandom(32'd2024));
        for (int a = 0; a < 4; a++) for (int b = 0; b < 4; b++) begin
            m_vpn[a][b] = 0; m_ppn[a][b] = 0; m_asid[a][b] = 0; m_attr[a][b] = 0;
        end
        m_rasid = 32'h0403_0201; m_rr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset valid low", 128'(res_valid), 128'(0));

        lookup(32'hD000_1234, 2'd0, 2'd0, "R11 R1 fixed 0xD0 load");
        lookup(32'h0040_0000, 2'd0, 2'd0, "R1 R3 refill miss after reset");
        lookup(32'h0040_0000, 2'd2, 2'd0, "R3 fetch miss");
        lookup(32'hF000_0010, 2'd2, 2'd0, "R11 R8 fixed 0xF0 fetch");
        lookup(32'hD800_0000, 2'd1, 2'd0, "R11 fixed 0xD8 store");
        lookup(32'hE123_4567, 2'd1, 2'd0, "R11 R8 fixed 0xE0 store");

        refill(20'h12345, 32'hABCDE025);
        lookup(32'h1234_5ABC, 2'd0, 2'd2, "R10 R9 refill load ring 2");
        lookup(32'h1234_5ABC, 2'd0, 2'd3, "R5 privilege fault");
        lookup(32'h1234_5ABC, 2'd2, 2'd3, "R5 fetch privilege fault");
        lookup(32'h1234_5ABC, 2'd1, 2'd0, "R7 store prohibited");
        lookup(32'h1234_5ABC, 2'd2, 2'd0, "R7 fetch granted");
        lookup(32'h1234_5ABC, 2'd3, 2'd0, "R7 reserved kind");
        refill(20'h12345, 32'h1111_1003);
        lookup(32'h1234_5000, 2'd0, 2'd0, "R4 data multi-hit");
        lookup(32'h1234_5000, 2'd2, 2'd0, "R4 fetch multi-hit");
        refill(20'hD0000, 32'h2222_2003);
        lookup(32'hD000_0044, 2'd0, 2'd0, "R4 multi-hit with fixed way");

        set_rasid(32'h0109_0102);
        lookup(32'h1234_5000, 2'd0, 2'd0, "R2 identifier lost its ring");
        lookup(32'hE000_0100, 2'd0, 2'd1, "R2 lowest matching byte ring 1");
        lookup(32'hE000_0100, 2'd0, 2'd2, "R2 R5 fixed way below priv");
        set_rasid(32'h0403_0001);
        refill(20'h00ABC, 32'h3333_3013);
        lookup(32'h00AB_C000, 2'd0, 2'd0, "R3 zero identifier never hits");
        set_rasid(32'h0403_0201);

        refill(20'h55551, 32'h4444_400D);
        lookup(32'h5555_1008, 2'd1, 2'd0, "R6 isolate code 13");
        lookup(32'h5555_1008, 2'd2, 2'd0, "R7 isolate fetch denied");
        refill(20'h55552, 32'h4444_500E);
        lookup(32'h5555_2008, 2'd0, 2'd0, "R6 code 14 grants nothing");
        refill(20'h55553, 32'h4444_600B);
        lookup(32'h5555_3FFF, 2'd1, 2'd0, "R6 write-through code 11");

        // R12: lookup in the same cycle as a refill sees the old contents
        @(negedge clk);
        rf_valid = 1; rf_vpn = 20'h00777; rf_pte = 32'h7777_7007;
        lk_valid = 1; lk_vaddr = 32'h0077_7010; lk_kind = 2'd0; lk_priv = 2'd0;
        e = expect_vec(32'h0077_7010, 2'd0, 2'd0);
        model_refill(20'h00777, 32'h7777_7007);
        @(negedge clk);
        rf_valid = 0; lk_valid = 0;
        check("R12 same-cycle refill unseen", 128'({res_valid, res_cause}), 128'({1'b1, e[77:72]}));
        @(negedge clk);
        check("R12 valid drops without lookup", 128'(res_valid), 128'(0));
        lookup(32'h0077_7010, 2'd0, 2'd0, "R12 refill seen next lookup");

        for (int i = 0; i < 8; i++) pool[i] = 20'($urandom);
        pool[1] = {pool[0][19:2], ~pool[0][1:0]};
        for (int it = 0; it < 1500; it++) begin
            int op;
            logic [31:0] va;
            op = $urandom_range(0, 99);
            if (op < 25) begin
                refill(pool[$urandom_range(0, 7)], $urandom);
            end else if (op < 29) begin
                set_rasid({8'($urandom_range(0, 5)), 8'($urandom_range(0, 5)),
                           8'($urandom_range(0, 5)), 8'($urandom_range(0, 5))});
            end else begin
                if (op < 75)      va = {pool[$urandom_range(0, 7)], 12'($urandom)};
                else if (op < 90) va = {3'($urandom_range(6, 7)), 29'($urandom)};
                else              va = $urandom;
                if (op % 7 == 0) pte_base = $urandom;
                lookup(va, 2'($urandom), 2'($urandom), "R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule